// File: doc/BRIEF.md
# IrDA SIR pulse modem

This block is a serial infrared modem for the slow IR rate. Each byte is framed as on a UART, with one start bit, eight data bits and one stop bit. The line does not hold a level for each bit. A zero bit becomes a short optical pulse and a one bit becomes darkness. On the transmit side a byte is accepted through a valid/ready handshake, serialised least significant bit first, and sent on an active-high pulse output that rests low. On the receive side the pulse input is watched, the frame is rebuilt and the byte is returned with a framing-error flag.

A free-running divider sets the timing. It produces a 16x oversampling tick once every `baud_div + 1` clocks, and 16 ticks make one bit period. A mode input picks the zero-bit pulse. It is either 3/16 of a bit (ticks 0 to 2 of the bit) or a fixed number of clocks set by a parameter, which is meant to be sized to roughly 1.6 us. The receiver cuts the line into 16-tick windows that are shifted by half a bit from its start detection. A pulse in a window reads as 0 and no pulse reads as 1.

Top module: `irsir_modem`

## Requirements
- R1: `tx_ready` is high exactly when the transmitter is idle. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low on the next cycle and stays low until the frame ends.
- R2: A tick occurs once every `baud_div + 1` clocks. The start bit begins on the first tick after acceptance. Each of the 10 bits lasts 16 ticks, in the order start (0), data bit 0 to data bit 7 (LSB first), stop (1). `tx_ready` returns high exactly 160·(`baud_div`+1) clocks after the start-bit pulse rises.
- R3: With `pulse_fixed` = 0, every zero bit drives `ir_tx` high for exactly 3·(`baud_div`+1) clocks. The pulse starts in the cycle after the tick that opens the bit.
- R4: Every one bit, including the stop bit, leaves `ir_tx` low for the whole bit, and `ir_tx` is low while idle.
- R5: With `pulse_fixed` = 1, every zero bit drives `ir_tx` high for exactly `FIXED_PULSE_CYC` clocks from the same starting point as in R3.
- R6: The receiver decodes a pulse as 0 and no pulse as 1. It raises `rx_valid` for one cycle with the byte on `rx_data` and `rx_ferr` = 0 when the stop window holds no pulse.
- R7: A pulse inside the stop-bit window still delivers the byte, but with `rx_ferr` = 1, and the next frame is received normally.
- R8: A character starts when the line goes high while the receiver is idle. Looping `ir_tx` back to `ir_rx` returns every transmitted byte for `baud_div` 0 to 3 in both pulse modes.
- R9: While `rst_n` is low and right after it is released, `ir_tx` is low, `tx_ready` is high and `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | DIV_W | Tick divisor; one tick per baud_div+1 clocks |
| pulse_fixed | input | 1 | 0: 3/16-bit pulse, 1: FIXED_PULSE_CYC-clock pulse |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmitter idle, can accept a byte |
| ir_tx | output | 1 | Pulse output, active high |
| ir_rx | input | 1 | Pulse input, active high, asynchronous |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | One-cycle strobe: rx_data and rx_ferr are new |
| rx_ferr | output | 1 | Pulse seen in the stop window |

## Verification
The bench sends all 256 byte values and measures the time of every pulse edge. A design that sent the bits MSB first, or that left out the pulse for a zero start bit, would show the wrong pulse count or wrong pulse positions. An off-by-one in the tick divider or the phase counter shows up as pulse widths or a frame length that are wrong by whole ticks, and the bench sweeps several divisors, including the one-clock tick, to expose it. Hand-driven receive frames carry a stop-bit pulse. A receiver that ignored the stop window would then never raise the error flag, and one that lost its alignment after the error would corrupt the next byte.

// File: rtl/irsir_pkg.sv
// Shared constants and state types for the slow-IR pulse modem.
package irsir_pkg;
    localparam int OSR        = 16; // ticks per bit period
    localparam int ZERO_TICKS = 3;  // ticks a zero-bit pulse lasts in 3/16 mode
    localparam int HALF_BIT   = OSR / 2;

    typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;
endpackage

// File: rtl/irsir_tick_gen.sv
// Oversampling tick generator.
// Raises tick for one clock every baud_div+1 clocks. If baud_div shrinks
// below the running count, the counter wraps at the next clock.
module irsir_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= baud_div);

    // Free-running divide counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && baud_div != '0) |=> (!tick || !$stable(baud_div))); // R2
endmodule

// File: rtl/irsir_tx.sv
// Pulse transmitter.
// Takes a byte through valid/ready and waits for the next tick. It then
// sends start, data LSB first and stop, each for OSR ticks. A zero bit is
// sent as a short high pulse and a one bit as a low line. Assumes
// FIXED_PULSE_CYC is shorter than one bit period.
module irsir_tx
    import irsir_pkg::*;
#(
    parameter int DATA_W          = 8,
    parameter int FIXED_PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pulse_fixed,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              ir_tx
);
    localparam int FRAME = DATA_W + 2;
    localparam int IDX_W = $clog2(FRAME);
    localparam int PH_W  = $clog2(OSR);
    localparam int FC_W  = $clog2(FIXED_PULSE_CYC + 1);

    tx_state_t        state;
    logic [FRAME-1:0] frame_q;
    logic [IDX_W-1:0] idx;
    logic [PH_W-1:0]  ph;
    logic [FC_W-1:0]  fcnt;
    logic             bit_end;
    logic             in_pulse;

    assign bit_end  = tick && (ph == PH_W'(OSR - 1));
    assign tx_ready = (state == TX_IDLE);
    assign in_pulse = pulse_fixed ? (fcnt < FC_W'(FIXED_PULSE_CYC))
                                  : (ph < PH_W'(ZERO_TICKS));
    assign ir_tx    = (state == TX_SEND) && !frame_q[0] && in_pulse;

    // Frame sequencer: accept, align to tick, step bit phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            frame_q <= '1;
            idx     <= '0;
            ph      <= '0;
        end else begin
            case (state)
                TX_IDLE: if (tx_valid) begin
                    frame_q <= {1'b1, tx_data, 1'b0};
                    state   <= TX_WAIT;
                end
                TX_WAIT: if (tick) begin
                    state <= TX_SEND;
                    idx   <= '0;
                    ph    <= '0;
                end
                TX_SEND: if (bit_end) begin
                    ph <= '0;
                    if (idx == IDX_W'(FRAME - 1)) begin
                        state <= TX_IDLE;
                    end else begin
                        idx     <= idx + 1'b1;
                        frame_q <= {1'b1, frame_q[FRAME-1:1]};
                    end
                end else if (tick) begin
                    ph <= ph + 1'b1;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // Clock counter since the start of the current bit, for fixed pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fcnt <= '0;
        else if ((state == TX_WAIT && tick) || (state == TX_SEND && bit_end))
            fcnt <= '0;
        else if (fcnt != FC_W'(FIXED_PULSE_CYC))
            fcnt <= fcnt + 1'b1;
    end

    AST_TX_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready); // R1
    AST_TX_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ir_tx) && $stable(pulse_fixed)) |-> $past(tick)); // R3
    AST_TX_STOP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SEND && idx == IDX_W'(FRAME - 1)) |-> !ir_tx); // R4
endmodule

// File: rtl/irsir_rx.sv
// Pulse receiver.
// Synchronises ir_rx. A high line while idle starts a character. The
// receiver then waits half a bit and cuts the line into OSR-tick windows
// that straddle the transmitter's bit starts. Any high clock inside a
// window reads as 0. The last window is the stop bit, and a pulse there
// sets the framing error. Assumes pulses are shorter than half a bit.
module irsir_rx
    import irsir_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ir_rx,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_ferr
);
    localparam int PH_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W + 1);

    rx_state_t         state;
    logic              sync1, line;
    logic [PH_W-1:0]   ph;
    logic [IDX_W-1:0]  idx;
    logic              seen;
    logic              hit;
    logic [DATA_W-1:0] shreg;

    assign hit = seen | line;

    // Two-flop synchroniser for the asynchronous pulse input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            line  <= 1'b0;
        end else begin
            sync1 <= ir_rx;
            line  <= sync1;
        end
    end

    // Character sequencer: detect start, step windows, deliver byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            ph       <= '0;
            idx      <= '0;
            seen     <= 1'b0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            case (state)
                RX_IDLE: if (line) begin
                    state <= RX_START;
                    ph    <= '0;
                end
                RX_START: if (tick) begin
                    if (ph == PH_W'(HALF_BIT - 1)) begin
                        state <= RX_BITS;
                        ph    <= '0;
                        idx   <= '0;
                        seen  <= 1'b0;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                RX_BITS: begin
                    seen <= hit;
                    if (tick && ph == PH_W'(OSR - 1)) begin
                        seen <= 1'b0;
                        ph   <= '0;
                        if (idx == IDX_W'(DATA_W)) begin
                            rx_valid <= 1'b1;
                            rx_ferr  <= hit;
                            rx_data  <= shreg;
                            state    <= RX_IDLE;
                        end else begin
                            shreg <= {~hit, shreg[DATA_W-1:1]};
                            idx   <= idx + 1'b1;
                        end
                    end else if (tick) begin
                        ph <= ph + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    AST_RX_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6
    AST_RX_BACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (state == RX_IDLE)); // R6
    AST_RX_START_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && $past(state) == RX_IDLE) |-> $past(line)); // R8
endmodule

// File: rtl/irsir_modem.sv
// Slow-IR pulse modem top level: one shared tick generator, the
// transmitter and the receiver. The two directions are independent
// apart from sharing the tick.
module irsir_modem #(
    parameter int DIV_W           = 16,
    parameter int DATA_W          = 8,
    parameter int FIXED_PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              pulse_fixed,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              ir_tx,
    input  logic              ir_rx,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_ferr
);
    logic tick;

    irsir_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tick(tick)
    );

    irsir_tx #(.DATA_W(DATA_W), .FIXED_PULSE_CYC(FIXED_PULSE_CYC)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pulse_fixed(pulse_fixed),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .ir_tx(ir_tx)
    );

    irsir_rx #(.DATA_W(DATA_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ir_rx(ir_rx),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
    );
endmodule

// File: tb/irsir_modem_tb_top.sv
// Self-checking bench: full byte sweep over loopback, divisor and mode
// sweep, and hand-driven receive frames with stop-bit errors.
module irsir_modem_tb_top;
    localparam int DIV_W = 8;
    localparam int FIX   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] baud_div = '0;
    logic             pulse_fixed = 1'b0;
    logic [7:0]       tx_data = '0;
    logic             tx_valid = 1'b0;
    logic             tx_ready, ir_tx, ir_rx, rx_valid, rx_ferr;
    logic [7:0]       rx_data;
    logic             loop_en = 1'b0;
    logic             drv_rx = 1'b0;

    int nchk = 0, nfail = 0, cyc = 0;
    int np = 0, rx_cnt = 0;
    int rise_t[16];
    int wid[16];
    logic       prev_tx = 1'b0;
    logic [7:0] rx_b = '0;
    logic       rx_f = 1'b0;
    bit         done = 0;

    assign ir_rx = loop_en ? ir_tx : drv_rx;

    always #4 clk = ~clk;

    irsir_modem #(.DIV_W(DIV_W), .DATA_W(8), .FIXED_PULSE_CYC(FIX)) dut_i (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .pulse_fixed(pulse_fixed),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .ir_tx(ir_tx),
        .ir_rx(ir_rx), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
    );

    always @(posedge clk) cyc = cyc + 1;

    // Pulse-edge and receive capture, plus watchdog.
    always @(negedge clk) begin
        if (ir_tx && !prev_tx && np < 16) rise_t[np] = cyc;
        if (!ir_tx && prev_tx && np < 16) begin
            wid[np] = cyc - rise_t[np];
            np = np + 1;
        end
        prev_tx = ir_tx;
        if (rx_valid) begin
            rx_cnt = rx_cnt + 1;
            rx_b   = rx_data;
            rx_f   = rx_ferr;
        end
        if (cyc > 195000 && !done) begin
            nfail = nfail + 1;
            $display("FAIL watchdog R2 actual=%0d cycles expected=finish", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Send one byte, then check pulse timing and the looped-back byte.
    task automatic send(input logic [7:0] b, input int div, input bit fx);
        int acc, rdy, rx0, nexp, j, per, w;
        logic [9:0] fr;
        baud_div    = DIV_W'(div);
        pulse_fixed = fx;
        for (int i = 0; i < 50 && !tx_ready; i++) step();
        np = 0;
        rx0 = rx_cnt;
        tx_data  = b;
        tx_valid = 1'b1;
        step();
        acc = cyc;
        tx_valid = 1'b0;
        chk(!tx_ready, "R1 ready low after accept", tx_ready, 0);
        rdy = -1;
        for (int i = 0; i < 200 * (div + 1); i++) begin
            step();
            if (tx_ready) begin
                rdy = cyc;
                break;
            end
        end
        step();
        per = 16 * (div + 1);
        w   = fx ? FIX : 3 * (div + 1);
        fr  = {1'b1, b, 1'b0};
        nexp = 0;
        for (int k = 0; k < 10; k++) if (!fr[k]) nexp++;
        chk(np == nexp, "R3 R4 pulse count", np, nexp);
        if (np > 0) begin
            chk(rise_t[0] - acc >= 1 && rise_t[0] - acc <= div + 1,
                "R2 start after first tick", rise_t[0] - acc, 1);
            chk(rdy - rise_t[0] == 10 * per, "R2 frame length", rdy - rise_t[0], 10 * per);
            j = 0;
            for (int k = 0; k < 10; k++) begin
                if (!fr[k] && j < np) begin
                    chk(rise_t[j] - rise_t[0] == k * per, "R2 bit position LSB first",
                        rise_t[j] - rise_t[0], k * per);
                    chk(wid[j] == w, fx ? "R5 fixed pulse width" : "R3 pulse width",
                        wid[j], w);
                    j++;
                end
            end
        end
        chk(rx_cnt == rx0 + 1, "R6 R8 one byte delivered", rx_cnt - rx0, 1);
        chk(rx_b == b, "R6 R8 loopback data", rx_b, b);
        chk(!rx_f, "R6 no framing error", rx_f, 0);
    endtask

    // Hand-drive one receive frame; stop_pulse puts a pulse in the stop bit.
    task automatic rx_frame(input logic [7:0] b, input bit stop_pulse, input int div);
        int rx0;
        logic [9:0] fr;
        rx0 = rx_cnt;
        fr = {!stop_pulse, b, 1'b0};
        baud_div = DIV_W'(div);
        for (int k = 0; k < 10; k++)
            for (int c = 0; c < 16 * (div + 1); c++) begin
                drv_rx = !fr[k] && (c < 3 * (div + 1));
                step();
            end
        drv_rx = 1'b0;
        for (int i = 0; i < 8 * (div + 1); i++) step();
        chk(rx_cnt == rx0 + 1, "R7 delivered", rx_cnt - rx0, 1);
        chk(rx_b == b, "R7 data", rx_b, b);
        chk(rx_f == stop_pulse, "R7 framing flag", rx_f, stop_pulse);
    endtask

    initial begin
        logic [7:0] pat [4];
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5; pat[3] = 8'h3C;
        for (int i = 0; i < 4; i++) step();
        chk(!ir_tx, "R9 ir_tx low in reset", ir_tx, 0);
        chk(tx_ready, "R9 tx_ready high in reset", tx_ready, 1);
        rst_n = 1'b1;
        step();
        chk(!ir_tx, "R9 ir_tx low after reset", ir_tx, 0);
        chk(tx_ready, "R9 tx_ready after reset", tx_ready, 1);
        chk(!rx_valid, "R9 rx_valid low after reset", rx_valid, 0);
        baud_div = DIV_W'(1);
        for (int i = 0; i < 40; i++) step();
        chk(!ir_tx, "R4 idle line low", ir_tx, 0);
        loop_en = 1'b1;
        for (int b = 0; b < 256; b++) send(8'(b), 1, 1'b0);
        for (int d = 0; d < 4; d++)
            for (int f = 0; f < 2; f++)
                for (int p = 0; p < 4; p++) send(pat[p], d, f[0]);
        loop_en = 1'b0;
        for (int i = 0; i < 50; i++) step();
        rx_frame(8'h5A, 1'b0, 2);
        rx_frame(8'hC3, 1'b1, 2);
        rx_frame(8'h0F, 1'b0, 2);
        rx_frame(8'h00, 1'b1, 0);
        rx_frame(8'h81, 1'b0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule